// File: doc/BRIEF.md
# Timer Count Source Selector

This block decides when an 8-bit timer/event counter advances. Everything runs on the peripheral clock. It issues a single-cycle count-enable strobe, `cnt_en`. A 3-bit code held in an 8-bit control register picks where the strobe comes from. The first two codes take it from an external event pin, counting either falling or rising edges. The other six codes take it from taps of a free-running 13-bit prescaler, giving divisions of 1, 2, 4, 64, 256 and 8192.

The control register is written through a simple write strobe and is always visible on the read-back port. Some writes are refused:

- a write made while the timer is running;
- a write of the undivided-clock code while the low-voltage mode input is asserted.

A refused write leaves the register as it was and raises a sticky error flag. The next accepted write clears that flag.

Top module: `tmr_cksel`

## Requirements
- R1: After reset the read-back value is 8'h00 and `wr_err` is 0, so the active source is the falling edge of `evt_in` (code 000).
- R2: Read-back bits 7..3 are always 0, whatever value was written to them; bits 2..0 return the last accepted code.
- R3: With code 000 in bits 2..0, each falling edge of `evt_in` gives exactly one `cnt_en` pulse, high in the second cycle after the input changes; rising edges give none.
- R4: With code 001, each rising edge of `evt_in` gives exactly one `cnt_en` pulse with the same two-cycle latency; falling edges give none.
- R5: With code 010, `cnt_en` is high on every cycle.
- R6: With codes 011 and 100, `cnt_en` is a one-cycle pulse repeating every 2 and every 4 cycles respectively.
- R7: With codes 101, 110 and 111, `cnt_en` is a one-cycle pulse repeating every 64, 256 and 8192 cycles respectively.
- R8: A write while `tmr_run` is 1 leaves the register unchanged and sets `wr_err`.
- R9: A write of code 010 while `lowv_mode` is 1 (and `tmr_run` is 0) leaves the register unchanged and sets `wr_err`; other codes are still accepted in that mode.
- R10: An accepted write (timer stopped and not rejected by R9) loads bits 2..0 and clears `wr_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read-back |
| evt_in | input | 1 | External event input (asynchronous) |
| tmr_run | input | 1 | Timer running flag; writes are refused while it is high |
| lowv_mode | input | 1 | Low-voltage mode; the undivided code is refused while it is high |
| cnt_en | output | 1 | Single-cycle count-enable strobe |
| wr_err | output | 1 | Sticky error flag for refused writes |

## Verification
A write takes effect on the rising edge where `wr_en` is sampled. So `rd_data` and `wr_err` are checked at the next falling edge. An external edge must pass two synchronizer flops before it is compared with a third flop. The bench therefore changes `evt_in` on a falling edge and expects the strobe exactly two falling edges later, and nowhere else in a six-cycle window. Prescaler taps have no fixed phase relative to a write. For those codes the bench first locks onto one pulse, then measures the exact gap to each following pulse, sampling only on falling clock edges.

// File: rtl/tmr_cksel_pkg.sv
package tmr_cksel_pkg;

  localparam int unsigned SEL_W  = 3;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned PRE_W  = 13;
  localparam int unsigned NCODE  = 1 << SEL_W;
  localparam int unsigned FIRST_TAP = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_FALL    = 3'd0,
    SRC_RISE    = 3'd1,
    SRC_DIV1    = 3'd2,
    SRC_DIV2    = 3'd3,
    SRC_DIV4    = 3'd4,
    SRC_DIV64   = 3'd5,
    SRC_DIV256  = 3'd6,
    SRC_DIV8192 = 3'd7
  } src_e;

  // log2 of the division ratio selected by a prescaler code
  function automatic int unsigned tap_log2(input src_e code);
    case (code)
      SRC_DIV2:    return 1;
      SRC_DIV4:    return 2;
      SRC_DIV64:   return 6;
      SRC_DIV256:  return 8;
      SRC_DIV8192: return 13;
      default:     return 0;
    endcase
  endfunction

  // A tap fires when the low lg bits of the prescaler are all ones
  function automatic logic tap_fire(input logic [PRE_W-1:0] cnt, input int unsigned lg);
    logic f;
    f = 1'b1;
    for (int i = 0; i < int'(PRE_W); i++) begin
      if (i < int'(lg)) f = f & cnt[i];
    end
    return f;
  endfunction

  // Writes that must be refused
  function automatic logic write_refused(input logic run, input logic lowv,
                                         input logic [SEL_W-1:0] code);
    return run || (lowv && (code == SRC_DIV1));
  endfunction

endpackage

// File: rtl/tmr_cksel_reg.sv
module tmr_cksel_reg
  import tmr_cksel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             tmr_run,
  input  logic             lowv_mode,
  output logic [REG_W-1:0] rd_data,
  output src_e             sel,
  output logic             wr_err
);

  localparam logic [REG_W-1:0] WR_MASK = {{(REG_W-SEL_W){1'b0}}, {SEL_W{1'b1}}};

  logic [REG_W-1:0] reg_q;
  logic             err_q;
  logic             wr_reject;
  logic             wr_accept;

  assign wr_reject = wr_en &&  write_refused(tmr_run, lowv_mode, wr_data[SEL_W-1:0]);
  assign wr_accept = wr_en && !write_refused(tmr_run, lowv_mode, wr_data[SEL_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= '0;
      err_q <= 1'b0;
    end else if (wr_accept) begin
      reg_q <= wr_data & WR_MASK;
      err_q <= 1'b0;
    end else if (wr_reject) begin
      err_q <= 1'b1;
    end
  end

  assign rd_data = reg_q;
  assign sel     = src_e'(reg_q[SEL_W-1:0]);
  assign wr_err  = err_q;

  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:SEL_W] == '0);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tmr_run) |=> ($stable(reg_q) && err_q));

  assert_lowv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tmr_run && lowv_mode && wr_data[SEL_W-1:0] == SRC_DIV1)
      |=> ($stable(reg_q) && err_q));

  assert_accept_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (reg_q[SEL_W-1:0] == $past(wr_data[SEL_W-1:0]) && !err_q));

endmodule

// File: rtl/tmr_cksel_edge.sv
module tmr_cksel_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_in,
  output logic rise_pulse,
  output logic fall_pulse
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   evt_sync;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= evt_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign evt_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= evt_sync;
  end

  assign rise_pulse =  evt_sync && !prev_q;
  assign fall_pulse = !evt_sync &&  prev_q;

  assert_rise_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);

  assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/tmr_cksel_presc.sv
module tmr_cksel_presc
  import tmr_cksel_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [NCODE-1:FIRST_TAP]     taps
);

  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  generate
    for (genvar g = FIRST_TAP; g < NCODE; g++) begin : g_tap
      localparam logic [SEL_W-1:0] CODE = SEL_W'(g);
      assign taps[g] = tap_fire(cnt_q, tap_log2(src_e'(CODE)));
      if (g > FIRST_TAP) begin : g_nest
        // a slower tap can only fire together with every faster tap
        assert_tap_nested_R7: assert property (@(posedge clk) disable iff (!rst_n)
          taps[g] |-> taps[g-1]);
      end
    end
  endgenerate

endmodule

// File: rtl/tmr_cksel.sv
module tmr_cksel
  import tmr_cksel_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       evt_in,
  input  logic       tmr_run,
  input  logic       lowv_mode,
  output logic       cnt_en,
  output logic       wr_err
);

  src_e                     sel;
  logic                     rise_pulse;
  logic                     fall_pulse;
  logic [NCODE-1:FIRST_TAP] taps;

  tmr_cksel_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tmr_run   (tmr_run),
    .lowv_mode (lowv_mode),
    .rd_data   (rd_data),
    .sel       (sel),
    .wr_err    (wr_err)
  );

  tmr_cksel_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_in     (evt_in),
    .rise_pulse (rise_pulse),
    .fall_pulse (fall_pulse)
  );

  tmr_cksel_presc u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .taps  (taps)
  );

  always_comb begin
    case (sel)
      SRC_FALL: cnt_en = fall_pulse;
      SRC_RISE: cnt_en = rise_pulse;
      default:  cnt_en = taps[sel];
    endcase
  end

  assert_edge_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SRC_FALL && cnt_en) |=> !cnt_en || !$stable(sel));

endmodule

// File: tb/tmr_cksel_tb.sv
module tmr_cksel_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       evt_in = 1'b0;
  logic       tmr_run = 1'b0;
  logic       lowv_mode = 1'b0;
  logic       cnt_en;
  logic       wr_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tmr_cksel u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .evt_in(evt_in), .tmr_run(tmr_run), .lowv_mode(lowv_mode),
    .cnt_en(cnt_en), .wr_err(wr_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // called at a falling edge; returns at the falling edge after the write
  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // change evt_in now; pulse expected only at the second falling edge
  task automatic edge_obs(input logic v, input bit expect_pulse, input string req);
    int cnt;
    int pos;
    cnt = 0;
    pos = -1;
    evt_in = v;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (cnt_en) begin
        cnt++;
        pos = i;
      end
    end
    check(cnt == (expect_pulse ? 1 : 0), req, cnt, expect_pulse ? 1 : 0);
    if (expect_pulse) check(pos == 2, req, pos, 2);
  endtask

  task automatic period_obs(input int period, input string req);
    int n;
    n = 0;
    while (!cnt_en && n <= period + 2) begin
      @(negedge clk);
      n++;
    end
    check(cnt_en == 1'b1, req, int'(cnt_en), 1);
    for (int p = 0; p < 3; p++) begin
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!cnt_en && n <= period + 2);
      check(n == period, req, n, period);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rd_data == 8'h00, "R1", rd_data, 0);
    check(wr_err == 1'b0, "R1", wr_err, 0);
    // R1/R3 default source counts falling edges only
    edge_obs(1'b1, 1'b0, "R3");
    edge_obs(1'b0, 1'b1, "R3");

    // R2 upper bits ignored, then R4 rising edges
    do_write(8'hF9);
    check(rd_data == 8'h01, "R2", rd_data, 1);
    check(wr_err == 1'b0, "R10", wr_err, 0);
    edge_obs(1'b1, 1'b1, "R4");
    edge_obs(1'b0, 1'b0, "R4");

    // R2 sweep of every code with noisy upper bits
    for (int c = 0; c < 8; c++) begin
      do_write({5'((c * 7 + 3) & 31), 3'(c)});
      check(rd_data == 8'(c), "R2", rd_data, c);
    end

    // R5 undivided clock
    do_write(8'h02);
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (cnt_en) hi++;
      end
      check(hi == 40, "R5", hi, 40);
    end

    // R6 and R7 divided taps
    do_write(8'h03); period_obs(2, "R6");
    do_write(8'h04); period_obs(4, "R6");
    do_write(8'h05); period_obs(64, "R7");
    do_write(8'h06); period_obs(256, "R7");
    do_write(8'h07); period_obs(8192, "R7");

    // R8 refused while running
    tmr_run = 1'b1;
    do_write(8'h03);
    check(rd_data == 8'h07, "R8", rd_data, 7);
    check(wr_err == 1'b1, "R8", wr_err, 1);
    tmr_run = 1'b0;
    @(negedge clk);
    check(wr_err == 1'b1, "R8", wr_err, 1);
    do_write(8'h00);
    check(rd_data == 8'h00, "R10", rd_data, 0);
    check(wr_err == 1'b0, "R10", wr_err, 0);

    // R9 low-voltage mode
    lowv_mode = 1'b1;
    do_write(8'h02);
    check(rd_data == 8'h00, "R9", rd_data, 0);
    check(wr_err == 1'b1, "R9", wr_err, 1);
    do_write(8'h03);
    check(rd_data == 8'h03, "R9", rd_data, 3);
    check(wr_err == 1'b0, "R10", wr_err, 0);
    lowv_mode = 1'b0;
    do_write(8'h02);
    check(rd_data == 8'h02, "R9", rd_data, 2);
    @(negedge clk);
    check(cnt_en == 1'b1, "R5", cnt_en, 1);

    finish_run();
  end

endmodule